// File: doc/BRIEF.md
# Rewindable Synchronous FIFO with Programmable Fill Flags

This block is a single-clock first-in first-out buffer. Words enter on a write strobe and leave through a registered output on a read strobe. Five active-low status outputs report the fill level: empty, near-empty, more-than-half, near-full and full. The near-empty and near-full thresholds are held in two offset registers. Both reset to 127, and a one-cycle load strobe with a select bit replaces either one.

A rewind input returns the read side to physical location zero and leaves the write side untouched. A producer can therefore send a packet, wait for the far end to acknowledge it, and send the same words again in their original order if needed. Words written after the rewind follow the replayed ones. The rewind is meaningful only when no more than the buffer depth has been written since reset and at least one word has been read. Under those conditions the whole depth can be replayed as often as wanted.

Top module: `rewind_fifo`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `dout` is 0, `empty_n` and `aempty_n` are low, `half_n`, `afull_n` and `full_n` are high, and both offsets hold 127.
- R2: Words are read out in the order they were written. `dout` takes the next word on the clock edge that accepts a read and holds its value at all other times.
- R3: A write while `full_n` is low is ignored. The stored level stays the same and no stored word is overwritten, unless a read in the same cycle makes room.
- R4: A read while `empty_n` is low is ignored, and `dout` keeps its value.
- R5: With level c and empty offset n, `empty_n` is low exactly when c = 0, and `aempty_n` is low exactly when c <= n.
- R6: `half_n` is low exactly when c > DEPTH/2.
- R7: With full offset m, `afull_n` is low exactly when c >= DEPTH - m, and `full_n` is low exactly when c = DEPTH.
- R8: A high `rt` sets the read position to location 0 and leaves the write position unchanged. From the next cycle all five flags reflect level = words written since reset.
- R9: When `rt` and `rd_en` are high in the same cycle, the rewind wins, no word is read, and `dout` holds.
- R10: After a rewind, reads return the previously read words in their original order, followed by any words written after the rewind. The full depth may be replayed repeatedly.
- R11: A cycle with `ld_en` high loads `ld_val` into the empty offset when `ld_sel` = 0, or into the full offset when `ld_sel` = 1. The other offset is unchanged. Reset restores both to 127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| din | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe |
| dout | output | DATA_W | Registered read data |
| rt | input | 1 | Rewind the read position to location 0 |
| ld_en | input | 1 | Offset load strobe |
| ld_sel | input | 1 | 0 selects the empty offset, 1 selects the full offset |
| ld_val | input | ADDR_W | New offset value |
| empty_n | output | 1 | Low when no word is stored |
| aempty_n | output | 1 | Low when level <= empty offset |
| half_n | output | 1 | Low when level > DEPTH/2 |
| afull_n | output | 1 | Low when level >= DEPTH - full offset |
| full_n | output | 1 | Low when level = DEPTH |

## Verification
The hardest case to reach is a rewind after exactly the full depth has been written and fully drained. At that point the write position sits on the wrap boundary, and a replay must reproduce all DEPTH words without touching location 0 twice. The stimulus gets there in two steps. First, a fill to full is followed by an extra write attempt, a complete drain, and a read attempt on the empty buffer. Then, after a fresh reset, the bench fills to full, drains, rewinds twice in a row, and checks every flag at every level against arithmetic thresholds, once with the default offsets and once with reloaded ones.

// File: rtl/rfifo_pkg.sv
// Package: shared types for the rewindable FIFO.
// Assumes: nothing beyond IEEE 1800-2017.
package rfifo_pkg;

    // Selects which threshold register a load strobe writes.
    typedef enum logic {
        OFS_EMPTY = 1'b0,
        OFS_FULL  = 1'b1
    } ofs_sel_e;

    // Active-low status flags, ordered from emptiest to fullest.
    typedef struct packed {
        logic empty_n;
        logic aempty_n;
        logic half_n;
        logic afull_n;
        logic full_n;
    } fill_flags_t;

endpackage

// File: rtl/rfifo_ptrs.sv
// Module: rfifo_ptrs
// Keeps the read and write positions, with one extra wrap bit each, and
// derives the fill level from them. A rewind clears only the read
// position and takes precedence over a read in the same cycle.
// Assumes: a rewind is issued only while total writes since reset <= DEPTH.
module rfifo_ptrs #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              rt,
    output logic [ADDR_W:0]   wr_ptr,
    output logic [ADDR_W:0]   rd_ptr,
    output logic [ADDR_W:0]   level,
    output logic              wr_go,
    output logic              rd_go
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W:0] LVL_FULL = (ADDR_W+1)'(DEPTH);

    // Level and acceptance of this cycle's requests.
    always_comb begin
        level = wr_ptr - rd_ptr;
        wr_go = wr_en && (level != LVL_FULL);
        rd_go = rd_en && (level != '0) && !rt;
    end

    // Write position: advances on every accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)      wr_ptr <= '0;
        else if (wr_go)  wr_ptr <= wr_ptr + 1'b1;
    end

    // Read position: cleared by a rewind, otherwise advances on accepted reads.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_ptr <= '0;
        else if (rt)     rd_ptr <= '0;
        else if (rd_go)  rd_ptr <= rd_ptr + 1'b1;
    end
endmodule

// File: rtl/rfifo_mem.sv
// Module: rfifo_mem
// Storage array with one write port and a registered read port. The
// output register changes only on an accepted read.
// Assumes: addresses are the low ADDR_W bits of the positions.
module rfifo_mem #(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_go,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_go,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    // Array write: no reset, contents are valid only once written.
    always_ff @(posedge clk) begin
        if (wr_go) store[wr_addr] <= wr_data;
    end

    // Output register: loads the addressed word on an accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_data <= '0;
        else if (rd_go)  rd_data <= store[rd_addr];
    end
endmodule

// File: rtl/rfifo_offsets.sv
// Module: rfifo_offsets
// Holds the near-empty and near-full thresholds. A load strobe writes the
// register named by the select bit; reset restores the default to both.
// Assumes: OFS_DEFAULT fits in ADDR_W bits.
module rfifo_offsets
    import rfifo_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int OFS_DEFAULT = 127
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic              ld_sel,
    input  logic [ADDR_W-1:0] ld_val,
    output logic [ADDR_W-1:0] empty_ofs,
    output logic [ADDR_W-1:0] full_ofs
);
    localparam logic [ADDR_W-1:0] OFS_INIT = ADDR_W'(OFS_DEFAULT);
    localparam int NUM_OFS = 2;

    logic [ADDR_W-1:0] ofs_q [NUM_OFS];

    for (genvar g = 0; g < NUM_OFS; g++) begin : g_ofs
        // One threshold register, written when the select bit names it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ofs_q[g] <= OFS_INIT;
            else if (ld_en && (ld_sel == 1'(g)))
                ofs_q[g] <= ld_val;
        end
    end

    assign empty_ofs = ofs_q[int'(OFS_EMPTY)];
    assign full_ofs  = ofs_q[int'(OFS_FULL)];
endmodule

// File: rtl/rfifo_flags.sv
// Module: rfifo_flags
// Decodes the fill level into five active-low flags against the two
// programmable thresholds and the fixed half-depth mark.
// Assumes: level never exceeds DEPTH.
module rfifo_flags
    import rfifo_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W:0]   level,
    input  logic [ADDR_W-1:0] empty_ofs,
    input  logic [ADDR_W-1:0] full_ofs,
    output fill_flags_t       flags
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W:0]   LVL_FULL = (ADDR_W+1)'(DEPTH);
    localparam logic [ADDR_W:0]   LVL_HALF = (ADDR_W+1)'(DEPTH / 2);
    localparam logic [ADDR_W+1:0] SUM_FULL = (ADDR_W+2)'(DEPTH);

    logic [ADDR_W+1:0] near_full_sum;

    // Threshold compares; near-full uses level + m >= DEPTH to avoid underflow.
    always_comb begin
        near_full_sum  = {1'b0, level} + {2'b00, full_ofs};
        flags.empty_n  = (level != '0);
        flags.aempty_n = (level > {1'b0, empty_ofs});
        flags.half_n   = !(level > LVL_HALF);
        flags.afull_n  = !(near_full_sum >= SUM_FULL);
        flags.full_n   = (level != LVL_FULL);
    end
endmodule

// File: rtl/rewind_fifo.sv
// Module: rewind_fifo (top)
// Single-clock FIFO with a registered output, a read-side rewind to
// location 0 for packet replay, and five active-low fill flags with
// loadable near-empty / near-full thresholds.
// Assumes: rewind is used only after <= DEPTH writes since reset.
module rewind_fifo
    import rfifo_pkg::*;
#(
    parameter int DATA_W      = 18,
    parameter int ADDR_W      = 8,
    parameter int OFS_DEFAULT = 127
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] din,
    input  logic              rd_en,
    output logic [DATA_W-1:0] dout,
    input  logic              rt,
    input  logic              ld_en,
    input  logic              ld_sel,
    input  logic [ADDR_W-1:0] ld_val,
    output logic              empty_n,
    output logic              aempty_n,
    output logic              half_n,
    output logic              afull_n,
    output logic              full_n
);
    logic [ADDR_W:0]   wr_ptr;
    logic [ADDR_W:0]   rd_ptr;
    logic [ADDR_W:0]   level;
    logic              wr_go;
    logic              rd_go;
    logic [ADDR_W-1:0] empty_ofs;
    logic [ADDR_W-1:0] full_ofs;
    fill_flags_t       flags;

    rfifo_ptrs #(.ADDR_W(ADDR_W)) u_ptrs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .rt     (rt),
        .wr_ptr (wr_ptr),
        .rd_ptr (rd_ptr),
        .level  (level),
        .wr_go  (wr_go),
        .rd_go  (rd_go)
    );

    rfifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_go   (wr_go),
        .wr_addr (wr_ptr[ADDR_W-1:0]),
        .wr_data (din),
        .rd_go   (rd_go),
        .rd_addr (rd_ptr[ADDR_W-1:0]),
        .rd_data (dout)
    );

    rfifo_offsets #(.ADDR_W(ADDR_W), .OFS_DEFAULT(OFS_DEFAULT)) u_ofs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_en     (ld_en),
        .ld_sel    (ld_sel),
        .ld_val    (ld_val),
        .empty_ofs (empty_ofs),
        .full_ofs  (full_ofs)
    );

    rfifo_flags #(.ADDR_W(ADDR_W)) u_flags (
        .level     (level),
        .empty_ofs (empty_ofs),
        .full_ofs  (full_ofs),
        .flags     (flags)
    );

    // Flag fan-out to the individual output pins.
    always_comb begin
        empty_n  = flags.empty_n;
        aempty_n = flags.aempty_n;
        half_n   = flags.half_n;
        afull_n  = flags.afull_n;
        full_n   = flags.full_n;
    end
endmodule

// File: rtl/rewind_fifo_chk.sv
// Module: rewind_fifo_chk
// Temporal checks on the rewindable FIFO, attached by bind.
// Assumes: bound into rewind_fifo, which exposes rd_ptr.
module rewind_fifo_chk #(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic              rt,
    input logic [DATA_W-1:0] dout,
    input logic              empty_n,
    input logic              aempty_n,
    input logic              half_n,
    input logic              afull_n,
    input logic              full_n,
    input logic [ADDR_W:0]   rd_ptr
);
    assert_full_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n && wr_en && !rd_en && !rt) |=> !full_n);

    assert_empty_read_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_n && rd_en) |=> $stable(dout));

    assert_empty_implies_aempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !empty_n |-> !aempty_n);

    assert_full_implies_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !full_n |-> (!afull_n && !half_n));

    assert_rewind_to_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rt |=> (rd_ptr == '0));

    assert_rewind_beats_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rt && rd_en) |=> $stable(dout));

    assert_not_empty_and_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~empty_n, ~full_n}) <= 1);
endmodule

bind rewind_fifo rewind_fifo_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .rt       (rt),
    .dout     (dout),
    .empty_n  (empty_n),
    .aempty_n (aempty_n),
    .half_n   (half_n),
    .afull_n  (afull_n),
    .full_n   (full_n),
    .rd_ptr   (rd_ptr)
);

// File: tb/rewind_fifo_bench.sv
module rewind_fifo_bench;
    localparam int DW = 18;
    localparam int AW = 8;
    localparam int D  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] din = '0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] dout;
    logic          rt = 1'b0;
    logic          ld_en = 1'b0;
    logic          ld_sel = 1'b0;
    logic [AW-1:0] ld_val = '0;
    logic          empty_n, aempty_n, half_n, afull_n, full_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Model state
    int m_wr = 0;
    int m_rd = 0;
    int m_n = 127;
    int m_m = 127;
    logic [DW-1:0] m_dout = '0;

    always #4 clk = ~clk;

    rewind_fifo #(.DATA_W(DW), .ADDR_W(AW)) u_rewind_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .din(din), .rd_en(rd_en),
        .dout(dout), .rt(rt), .ld_en(ld_en), .ld_sel(ld_sel), .ld_val(ld_val),
        .empty_n(empty_n), .aempty_n(aempty_n), .half_n(half_n),
        .afull_n(afull_n), .full_n(full_n)
    );

    function automatic logic [DW-1:0] pat(int i);
        return DW'((i * 37 + 11) ^ (i << 9));
    endfunction

    function automatic logic [4:0] exp_flags(int c, int n, int m);
        return {c != 0, c > n, !(c > D / 2), !(c >= D - m), c != D};
    endfunction

    task automatic check_flags(string tag);
        logic [4:0] got, exp;
        got = {empty_n, aempty_n, half_n, afull_n, full_n};
        exp = exp_flags(m_wr - m_rd, m_n, m_m);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s flags level=%0d actual=%b expected=%b", tag, m_wr - m_rd, got, exp);
        end
    endtask

    task automatic check_dout(string tag);
        checks++;
        if (dout !== m_dout) begin
            failures++;
            $display("FAIL %s dout actual=%h expected=%h", tag, dout, m_dout);
        end
    endtask

    // One clock: drive after the edge, wait for the next edge, settle.
    task automatic cyc(logic w, logic r, logic t, logic [DW-1:0] d);
        wr_en = w; rd_en = r; rt = t; din = d;
        @(posedge clk); #1;
        wr_en = 0; rd_en = 0; rt = 0;
    endtask

    task automatic push(string tag);
        bit ok;
        ok = (m_wr - m_rd) < D;
        cyc(1, 0, 0, pat(m_wr));
        if (ok) m_wr++;
        check_flags(tag);
    endtask

    task automatic pop(string tag);
        if (m_wr - m_rd > 0) begin
            m_dout = pat(m_rd);
            m_rd++;
        end
        cyc(0, 1, 0, '0);
        check_dout(tag);
        check_flags(tag);
    endtask

    task automatic rewind(logic with_read, string tag);
        cyc(0, with_read, 1, '0);
        m_rd = 0;
        check_dout(tag);
        check_flags(tag);
    endtask

    task automatic load(logic sel, int v);
        ld_en = 1; ld_sel = sel; ld_val = AW'(v);
        @(posedge clk); #1;
        ld_en = 0;
        if (sel) m_m = v; else m_n = v;
    endtask

    task automatic do_reset();
        rst_n = 0;
        @(posedge clk); #1;
        @(posedge clk); #1;
        rst_n = 1;
        m_wr = 0; m_rd = 0; m_n = 127; m_m = 127; m_dout = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset();
        check_dout("R1");
        check_flags("R1");

        // Full sweep with default thresholds: R5 R6 R7 at every level
        for (int i = 0; i < D; i++) push("R5 R6 R7 fill");
        push("R3 write while full");
        for (int i = 0; i < D; i++) pop("R2 R3 R5 R6 R7 drain");
        pop("R4 read while empty");
        push("R4 after empty read");
        pop("R2 R4");

        // R11: reload thresholds, sweep part of the range
        do_reset();
        load(1'b0, 5);
        check_flags("R11 empty offset load");
        load(1'b1, 10);
        check_flags("R11 full offset load");
        for (int i = 0; i < 20; i++) push("R5 R11 fill");
        for (int i = 0; i < 3; i++) pop("R2");
        rewind(1'b1, "R8 R9 rewind with read");
        push("R10 write after rewind");
        push("R10 write after rewind");
        for (int i = 0; i < 22; i++) pop("R10 replay");
        for (int i = m_wr - m_rd; i < D; i++) push("R6 R7 R11 fill");
        pop("R7 R11");

        // R11: reset restores defaults; full-depth replay twice (R8, R10)
        do_reset();
        check_flags("R1 R11 defaults");
        for (int i = 0; i < D; i++) push("R5 R11 default thresholds");
        for (int i = 0; i < D; i++) pop("R2");
        rewind(1'b0, "R8 full depth rewind");
        for (int i = 0; i < D; i++) pop("R10 first replay");
        rewind(1'b0, "R8 second rewind");
        for (int i = 0; i < D; i++) pop("R10 second replay");
        pop("R4 empty after replay");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule